// File: doc/BRIEF.md
# Digitally Calibrated Real-Time-Clock Prescaler

This block turns a nominal 32,768 Hz oscillator clock into a one-second tick and a one-minute tick. The rate is trimmed digitally rather than with trim capacitors. On a fixed schedule of 64 minutes, the block shortens or stretches the first second of some minutes by adjusting the divide-by-256 stage of the prescaler chain.

A six-bit calibration code sets the trim. Bits [4:0] hold a magnitude N (0 to 31). Bit [5] is the sign: 1 speeds the clock up and 0 slows it down. A magnitude of N corrects second 0 of minutes 0 to 2N-1 in every 64-minute cycle. A positive correction removes one count of the 256 stage, so that second is shorter by 256 oscillator cycles. A negative correction stretches one 256-cycle period by half, so that second is longer by 128 oscillator cycles. The code is sampled only when a cycle begins, so a write part-way through a cycle takes effect at the next cycle boundary.

For production trimming, a frequency-test mode drives an uncalibrated 512 Hz square wave onto a data line while the seconds register is read. The regular ticks stay muted until the mode is cleared. The power-fail reset clears the mode.

There is no data stream, so every pin is plain control or status with no valid/ready handshake. The divider lengths are parameters, so the schedule can be scaled down.

Top module: `rtc_cal_prescaler`

## Requirements
- R1: With no correction active, consecutive `sec_tick` pulses are FINE_DIV*COARSE_DIV running cycles apart. Each pulse lasts one cycle.
- R2: `min_tick` is high exactly on every SEC_PER_MIN-th `sec_tick` (the last second of each minute) and never without `sec_tick`.
- R3: With sign bit `cal_code[5]`=1 and magnitude `cal_code[4:0]`=N, second 0 of each minute m < 2N of the 64-minute cycle lasts FINE_DIV fewer cycles.
- R4: With `cal_code[5]`=0 and magnitude N, second 0 of each minute m < 2N lasts FINE_DIV/2 more cycles.
- R5: All other seconds are nominal. These are seconds 1 and up, minutes 2N and up, and every second when N is 0. At most one second per minute is altered.
- R6: `cal_code` is captured only during reset and at the end of the last second of minute MIN_PER_CYC-1. A change at any other time alters nothing until the next cycle begins.
- R7: While `osc_stop`=1, all counters hold their values, and `sec_tick`, `min_tick` and `ft_dq` are 0. Counting resumes from the held state.
- R8: When the test enable is set, `osc_stop`=0 and `rd_sec`=1, `ft_dq` is a square wave whose level changes every TEST_HALF running cycles, whatever the value of `cal_code`. Otherwise `ft_dq` is 0.
- R9: A cycle with `ft_we`=1 loads `ft_wdata` into the test enable at the next edge. While the enable is 1, `sec_tick` and `min_tick` stay 0.
- R10: `pf_rst`=1 clears the prescaler, the second and minute counters and the test enable, and makes all outputs 0. It does not clear the calibration: the code on `cal_code` is applied from the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock (nominally 32,768 Hz) |
| pf_rst | input | 1 | Power-fail reset, asynchronous, active high |
| cal_code | input | 6 | Calibration: [5] sign (1 = faster), [4:0] magnitude |
| osc_stop | input | 1 | 1 = oscillator stopped, all counting held |
| ft_we | input | 1 | Write strobe for the frequency-test enable |
| ft_wdata | input | 1 | Value written into the frequency-test enable |
| rd_sec | input | 1 | Seconds register is being read |
| sec_tick | output | 1 | One-cycle pulse at the end of each second |
| min_tick | output | 1 | One-cycle pulse at the end of each minute |
| ft_dq | output | 1 | 512 Hz test square wave on the data line |

## Verification
The bench times every second against a model of the 64-minute schedule. It goes after the boundary minute 2N-1 against 2N, the largest magnitude (62 corrected minutes), a zero magnitude, and a code changed part-way through a cycle.

Each fault shows up as a wrong second length. A window that is one minute off, or a correction applied in both directions, gives a wrong length. A code taken at once rather than at the cycle boundary corrects the wrong minutes. A stretch of a full 256 period instead of half gives 8 extra cycles instead of 4 at the bench's scale.

Random stop pulses check that no count is lost or doubled across a hold. The test-tap checks change the code while the tap runs, so a tap wired after the calibration logic would show an altered half period. A reset that cleared the calibration would let nominal seconds through where corrected ones are due.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int CAL_MAG_W = 5;

  typedef struct packed {
    logic                 pos;
    logic [CAL_MAG_W-1:0] mag;
  } cal_t;

  typedef enum logic [1:0] {
    ADJ_NONE  = 2'd0,
    ADJ_SHORT = 2'd1,
    ADJ_LONG  = 2'd2
  } adj_e;
endpackage

// File: rtl/rtc_cal_fine.sv
// Divide-by-FINE_DIV stage; one period can be stretched by half.
module rtc_cal_fine #(
  parameter int FINE_DIV = 256
) (
  input  logic clk,
  input  logic pf_rst,
  input  logic run,
  input  logic stretch,
  output logic lo_pulse
);
  localparam int LO_MAX = FINE_DIV + FINE_DIV / 2;
  localparam int LO_W   = $clog2(LO_MAX);

  logic [LO_W-1:0] cnt;
  logic [LO_W-1:0] term;

  assign term     = stretch ? LO_W'(LO_MAX - 1) : LO_W'(FINE_DIV - 1);
  assign lo_pulse = run && (cnt == term);

  always_ff @(posedge clk or posedge pf_rst) begin
    if (pf_rst) begin
      cnt <= '0;
    end else if (run) begin
      if (cnt == term) cnt <= '0;
      else             cnt <= cnt + 1'b1;
    end
  end

  // R7: a stopped oscillator freezes the fine counter
  assert_fine_hold_R7: assert property (@(posedge clk) disable iff (pf_rst)
    !run |=> $stable(cnt));

  // R10: the counter starts from zero after reset
  assert_fine_reset_R10: assert property (@(posedge clk) disable iff (pf_rst)
    $past(pf_rst) |-> (cnt == '0));
endmodule

// File: rtl/rtc_cal_coarse.sv
// Counts fine pulses into seconds; one count can be skipped.
module rtc_cal_coarse #(
  parameter int COARSE_DIV = 128
) (
  input  logic clk,
  input  logic pf_rst,
  input  logic lo_pulse,
  input  logic skip,
  output logic sec_pulse,
  output logic first
);
  localparam int HI_W = $clog2(COARSE_DIV);

  logic [HI_W-1:0] hi_cnt;
  logic [HI_W-1:0] term;

  assign term      = skip ? HI_W'(COARSE_DIV - 2) : HI_W'(COARSE_DIV - 1);
  assign sec_pulse = lo_pulse && (hi_cnt == term);
  assign first     = (hi_cnt == '0);

  always_ff @(posedge clk or posedge pf_rst) begin
    if (pf_rst) begin
      hi_cnt <= '0;
    end else if (lo_pulse) begin
      if (hi_cnt == term) hi_cnt <= '0;
      else                hi_cnt <= hi_cnt + 1'b1;
    end
  end

  // R1: every fine pulse inside a second advances the coarse count by one
  assert_coarse_step_R1: assert property (@(posedge clk) disable iff (pf_rst)
    (lo_pulse && !sec_pulse) |=> (hi_cnt == $past(hi_cnt) + 1'b1));
endmodule

// File: rtl/rtc_cal_sched.sv
// Second / minute-in-cycle counters and the correction schedule.
module rtc_cal_sched
  import rtc_cal_pkg::*;
#(
  parameter int SEC_PER_MIN = 60,
  parameter int MIN_PER_CYC = 64
) (
  input  logic clk,
  input  logic pf_rst,
  input  logic sec_pulse,
  input  cal_t cal_in,
  output adj_e adj,
  output logic min_pulse
);
  localparam int SEC_W = $clog2(SEC_PER_MIN);
  localparam int MIN_W = $clog2(MIN_PER_CYC);

  logic [SEC_W-1:0] sec_cnt;
  logic [MIN_W-1:0] min_cnt;
  cal_t             cal_q;
  logic             sec_last, min_last, win;

  assign sec_last  = (sec_cnt == SEC_W'(SEC_PER_MIN - 1));
  assign min_last  = (min_cnt == MIN_W'(MIN_PER_CYC - 1));
  assign min_pulse = sec_pulse && sec_last;
  assign win       = (sec_cnt == '0) && (int'(min_cnt) < 2 * int'(cal_q.mag));

  always_comb begin
    if (!win)          adj = ADJ_NONE;
    else if (cal_q.pos) adj = ADJ_SHORT;
    else               adj = ADJ_LONG;
  end

  always_ff @(posedge clk or posedge pf_rst) begin
    if (pf_rst) begin
      sec_cnt <= '0;
      min_cnt <= '0;
      cal_q   <= cal_in;
    end else if (sec_pulse) begin
      if (sec_last) begin
        sec_cnt <= '0;
        if (min_last) begin
          min_cnt <= '0;
          cal_q   <= cal_in;
        end else begin
          min_cnt <= min_cnt + 1'b1;
        end
      end else begin
        sec_cnt <= sec_cnt + 1'b1;
      end
    end
  end

  // R6: the applied code only changes as a new cycle begins
  assert_cal_hold_R6: assert property (@(posedge clk) disable iff (pf_rst)
    !$stable(cal_q) |-> (min_cnt == '0 && sec_cnt == '0));

  // R5: a corrected second is followed by an uncorrected one
  assert_one_adj_R5: assert property (@(posedge clk) disable iff (pf_rst)
    (adj != ADJ_NONE && sec_pulse) |=> (adj == ADJ_NONE));
endmodule

// File: rtl/rtc_cal_ftap.sv
// Uncalibrated test square wave, free running from the oscillator.
module rtc_cal_ftap #(
  parameter int TEST_HALF = 32
) (
  input  logic clk,
  input  logic pf_rst,
  input  logic run,
  input  logic ft_on,
  input  logic rd_sec,
  output logic ft_dq
);
  localparam int FT_W = (TEST_HALF > 1) ? $clog2(TEST_HALF) : 1;

  logic [FT_W-1:0] ft_cnt;
  logic            ft_sq, ft_last;

  assign ft_last = (ft_cnt == FT_W'(TEST_HALF - 1));
  assign ft_dq   = ft_on && run && rd_sec && ft_sq;

  always_ff @(posedge clk or posedge pf_rst) begin
    if (pf_rst) begin
      ft_cnt <= '0;
      ft_sq  <= 1'b0;
    end else if (run) begin
      if (ft_last) begin
        ft_cnt <= '0;
        ft_sq  <= ~ft_sq;
      end else begin
        ft_cnt <= ft_cnt + 1'b1;
      end
    end
  end

  // R8: the square wave holds its level between half-period boundaries
  assert_ft_half_R8: assert property (@(posedge clk) disable iff (pf_rst)
    (run && !ft_last) |=> $stable(ft_sq));

  // R7: a stopped oscillator freezes the test tap
  assert_ft_hold_R7: assert property (@(posedge clk) disable iff (pf_rst)
    !run |=> $stable(ft_cnt));
endmodule

// File: rtl/rtc_cal_prescaler.sv
module rtc_cal_prescaler
  import rtc_cal_pkg::*;
#(
  parameter int FINE_DIV    = 256,
  parameter int COARSE_DIV  = 128,
  parameter int SEC_PER_MIN = 60,
  parameter int MIN_PER_CYC = 64,
  parameter int TEST_HALF   = 32
) (
  input  logic       clk,
  input  logic       pf_rst,
  input  logic [5:0] cal_code,
  input  logic       osc_stop,
  input  logic       ft_we,
  input  logic       ft_wdata,
  input  logic       rd_sec,
  output logic       sec_tick,
  output logic       min_tick,
  output logic       ft_dq
);
  logic run, lo_pulse, sec_pulse, min_pulse, first, stretch, skip, ft_q;
  adj_e adj;
  cal_t cal_in;

  assign run     = !osc_stop;
  assign cal_in  = cal_t'(cal_code);
  assign stretch = (adj == ADJ_LONG) && first;
  assign skip    = (adj == ADJ_SHORT);

  rtc_cal_fine #(.FINE_DIV(FINE_DIV)) u_fine (
    .clk(clk), .pf_rst(pf_rst), .run(run), .stretch(stretch), .lo_pulse(lo_pulse)
  );

  rtc_cal_coarse #(.COARSE_DIV(COARSE_DIV)) u_coarse (
    .clk(clk), .pf_rst(pf_rst), .lo_pulse(lo_pulse), .skip(skip),
    .sec_pulse(sec_pulse), .first(first)
  );

  rtc_cal_sched #(.SEC_PER_MIN(SEC_PER_MIN), .MIN_PER_CYC(MIN_PER_CYC)) u_sched (
    .clk(clk), .pf_rst(pf_rst), .sec_pulse(sec_pulse), .cal_in(cal_in),
    .adj(adj), .min_pulse(min_pulse)
  );

  rtc_cal_ftap #(.TEST_HALF(TEST_HALF)) u_ftap (
    .clk(clk), .pf_rst(pf_rst), .run(run), .ft_on(ft_q), .rd_sec(rd_sec), .ft_dq(ft_dq)
  );

  always_ff @(posedge clk or posedge pf_rst) begin
    if (pf_rst)     ft_q <= 1'b0;
    else if (ft_we) ft_q <= ft_wdata;
  end

  assign sec_tick = sec_pulse && !ft_q;
  assign min_tick = min_pulse && !ft_q;

  // R10: the test enable is clear on leaving reset
  assert_ft_cleared_R10: assert property (@(posedge clk) disable iff (pf_rst)
    $past(pf_rst) |-> !ft_q);

  // R2: a minute tick always coincides with a second tick
  assert_min_on_sec_R2: assert property (@(posedge clk) disable iff (pf_rst)
    min_tick |-> sec_tick);
endmodule

// File: tb/rtc_cal_prescaler_bench.sv
`timescale 1ns/1ps
module rtc_cal_prescaler_bench;
  localparam int FD = 8;
  localparam int CD = 4;
  localparam int SPM = 4;
  localparam int MPC = 64;
  localparam int FH = 4;

  logic clk = 1'b0;
  logic pf_rst = 1'b1;
  logic [5:0] cal_code = 6'd0;
  logic osc_stop = 1'b0;
  logic ft_we = 1'b0;
  logic ft_wdata = 1'b0;
  logic rd_sec = 1'b0;
  logic sec_tick, min_tick, ft_dq;

  int checks = 0;
  int failures = 0;

  // model state
  bit   model_on = 0;
  bit   ft_mode = 0;
  int   cnt = 0;
  int   m_min = 0;
  int   m_sec = 0;
  logic [5:0] cal_eff = 6'd0;
  int   ft_run = 0;
  int   ft_trans = 0;
  logic ft_prev = 1'b0;

  always #5 clk = ~clk;

  rtc_cal_prescaler #(
    .FINE_DIV(FD), .COARSE_DIV(CD), .SEC_PER_MIN(SPM),
    .MIN_PER_CYC(MPC), .TEST_HALF(FH)
  ) u_rtc_cal_prescaler (
    .clk(clk), .pf_rst(pf_rst), .cal_code(cal_code), .osc_stop(osc_stop),
    .ft_we(ft_we), .ft_wdata(ft_wdata), .rd_sec(rd_sec),
    .sec_tick(sec_tick), .min_tick(min_tick), .ft_dq(ft_dq)
  );

  function automatic int exp_len(int mi, int se, logic [5:0] c);
    int l = FD * CD;
    if (se == 0 && mi < 2 * int'(c[4:0])) l = c[5] ? l - FD : l + FD / 2;
    return l;
  endfunction

  function automatic string len_tag(int mi, int se, logic [5:0] c, logic [5:0] cur);
    if (c != cur) return "R6";
    if (se == 0 && mi < 2 * int'(c[4:0])) return c[5] ? "R3" : "R4";
    if (c[4:0] != 0) return "R5";
    return "R1";
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic sample();
    if (osc_stop) begin
      check(!sec_tick && !min_tick && !ft_dq, "R7", {sec_tick, min_tick, ft_dq}, 0);
      return;
    end
    if (min_tick && !sec_tick) check(0, "R2", 1, 0);
    if (model_on) begin
      cnt++;
      if (sec_tick) begin
        check(cnt == exp_len(m_min, m_sec, cal_eff),
              len_tag(m_min, m_sec, cal_eff, cal_code), cnt, exp_len(m_min, m_sec, cal_eff));
        check(min_tick == (m_sec == SPM - 1), "R2", int'(min_tick), int'(m_sec == SPM - 1));
        cnt = 0;
        if (m_sec == SPM - 1) begin
          m_sec = 0;
          if (m_min == MPC - 1) begin
            m_min = 0;
            cal_eff = cal_code;
          end else m_min++;
        end else m_sec++;
      end
    end
    if (ft_mode) begin
      check(!sec_tick && !min_tick, "R9", {sec_tick, min_tick}, 0);
      if (rd_sec) begin
        if (ft_dq != ft_prev) begin
          if (ft_trans >= 1) check(ft_run == FH, "R8", ft_run, FH);
          ft_trans++;
          ft_run = 1;
          ft_prev = ft_dq;
        end else ft_run++;
      end else begin
        check(ft_dq == 1'b0, "R8", int'(ft_dq), 0);
      end
    end
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sample();
      @(posedge clk);
      #1;
    end
  endtask

  task automatic do_reset();
    pf_rst = 1'b1;
    model_on = 0;
    ft_mode = 0;
    @(negedge clk);
    rd_sec = 1'b1;
    #1;
    check(!sec_tick && !min_tick && !ft_dq, "R10", {sec_tick, min_tick, ft_dq}, 0);
    @(posedge clk);
    #1;
    pf_rst = 1'b0;
    rd_sec = 1'b0;
    cnt = 0; m_min = 0; m_sec = 0;
    cal_eff = cal_code;
    model_on = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    @(posedge clk); #1;
    do_reset();
    // R1 / R2: nominal cycle
    cyc(8400);
    // R3 / R6: small positive code written mid-cycle
    cal_code = {1'b1, 5'd1};
    cyc(2 * 8300);
    // R4: full negative range
    cal_code = {1'b0, 5'd31};
    cyc(2 * 8500);
    // random codes, random stops (R7), random reads
    for (int k = 0; k < 5; k++) begin
      cal_code = 6'($urandom_range(0, 63));
      for (int i = 0; i < 3000; i++) begin
        osc_stop = ($urandom_range(0, 7) == 0);
        rd_sec = 1'($urandom_range(0, 1));
        cyc(1);
      end
    end
    osc_stop = 1'b0;
    rd_sec = 1'b0;
    // R9 / R8: frequency test mode
    ft_we = 1'b1; ft_wdata = 1'b1;
    cyc(1);
    ft_we = 1'b0;
    model_on = 0;
    ft_mode = 1;
    rd_sec = 1'b1;
    ft_trans = 0; ft_run = 0; ft_prev = 1'b0;
    cyc(120);
    cal_code = {1'b1, 5'd31};
    cyc(60);
    osc_stop = 1'b1;
    cyc(7);
    osc_stop = 1'b0;
    cyc(60);
    check(ft_trans > 20, "R8", ft_trans, 21);
    rd_sec = 1'b0;
    cyc(30);
    // R10: reset clears the test mode, keeps the calibration
    cal_code = {1'b1, 5'd31};
    do_reset();
    rd_sec = 1'b1;
    cyc(8400);
    cal_code = {1'b0, 5'd0};
    cyc(9000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule